// File: doc/BRIEF.md
# ADC Serial Result Shifter

This block is the converter-side transmitter of a three-byte serial readout. A host pulls the active-low select line low and then runs 24 serial clock pulses. The clock idles low, and the host samples on each rising edge. The block answers on a single data line with a fixed 24-bit frame. The frame starts with eight zero bits. Next comes the 14-bit conversion result, most significant bit first. Last come two status bits, S1 and then S0. The result and the status are taken from parallel inputs at the moment the host selects the block. The host therefore reads a value that stays steady while it shifts.

The block runs on a fast local clock. The host's select and serial clock each pass through a synchronizer of `SYNC_STAGES` flops, and the block detects the serial clock edges after that. The data line is driven only while the block is selected. `sdo_en` is the enable for the output pad, so the pad is high-impedance whenever `sdo_en` is low.

The state machine has three states:
- `ST_IDLE`: deselected, output disabled.
- `ST_SHIFT`: frame in progress.
- `ST_TAIL`: all 24 bits sent, still selected.

It has four transitions:
- *select*: `ST_IDLE` to `ST_SHIFT`. The frame is loaded and the bit count cleared.
- *last-fall*: `ST_SHIFT` to `ST_TAIL`, on the 24th falling serial clock edge.
- *abort*: `ST_SHIFT` to `ST_IDLE`, when the host deselects mid-frame.
- *release*: `ST_TAIL` to `ST_IDLE`, when the host deselects.

Top module: `adc_result_shifter`

## Requirements
- R1: While `cs_n` is high, and after reset, `sdo_en` is 0 and `sdo` is 0.
- R2: `conv_result` and `conv_status` are captured when `cs_n` is seen low in `ST_IDLE`. Changes on those inputs during a frame have no effect on the bits sent.
- R3: While selected, `sdo` changes only after a falling edge of `sclk`. A rising edge of `sclk` never changes `sdo`.
- R4: Frame bits 0 to 7 are 0. Bit 0 is on `sdo` after selection and before the first rising edge of `sclk`. Bit k is on `sdo` after the k-th falling edge of `sclk`.
- R5: Frame bits 8 to 21 are `conv_result[13]` down to `conv_result[0]`.
- R6: Frame bit 22 is `conv_status[1]` and frame bit 23 is `conv_status[0]`.
- R7: After the 24th falling edge of `sclk`, while `cs_n` stays low, `sdo` is 0 and `sdo_en` is 1, whatever further `sclk` pulses arrive.
- R8: If `cs_n` rises before the 24th falling edge, `sdo_en` drops. The next selection restarts at frame bit 0 with a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the host signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from host |
| sclk | input | 1 | Host serial clock, idle low |
| conv_result | input | 14 | Parallel conversion result |
| conv_status | input | 2 | Status bits; [1] is sent before [0] |
| sdo | output | 1 | Serial data, 0 when not enabled |
| sdo_en | output | 1 | Output pad drive enable |

## Verification
The bench checks every bit of each frame just before the rising edge that would sample it, and checks it again while `sclk` is high. A design that shifts on the wrong edge, or that leaves out the zero byte or a status bit, shows up as a one-bit slip across the whole frame. The parallel inputs are changed mid-frame. A block that samples them live, instead of holding a copy, would leak the new value into the later bits. A frame is aborted after 13 bits and is followed by a new one. A counter that is not reset would resume mid-frame rather than at bit 0. Extra clocks are sent after bit 23; a block that wraps its count would begin sending the result again.

// File: rtl/adcsr_pkg.sv
package adcsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } sr_state_e;
endpackage

// File: rtl/adcsr_sync.sv
module adcsr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else if (STAGES == 1) chain[0] <= d;
                else chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adcsr_fall_det.sv
module adcsr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/adcsr_frame_reg.sv
module adcsr_frame_reg #(
    parameter int FRAME_W = 24,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    output logic               head_bit,
    output logic [CNT_W-1:0]   bit_cnt
);
    logic [FRAME_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            word_q  <= load_word;
            bit_cnt <= '0;
        end else if (shift) begin
            word_q  <= {word_q[FRAME_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign head_bit = word_q[FRAME_W-1];
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
    import adcsr_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int STAT_W      = 2,
    parameter int LEAD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [STAT_W-1:0] conv_status,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int FRAME_W = LEAD_W + RES_W + STAT_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    sr_state_e        state_q, state_d;
    logic             cs_s, sclk_s, sclk_fall;
    logic             load, shift, head_bit;
    logic [CNT_W-1:0] bit_cnt;

    adcsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));

    adcsr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));

    adcsr_fall_det u_fall (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .fall(sclk_fall));

    assign load  = (state_q == ST_IDLE)  && !cs_s;
    assign shift = (state_q == ST_SHIFT) && !cs_s && sclk_fall;

    adcsr_frame_reg #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_word({{LEAD_W{1'b0}}, conv_result, conv_status}),
        .shift(shift), .head_bit(head_bit), .bit_cnt(bit_cnt));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_s) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_s)                               state_d = ST_IDLE;
                else if (shift && bit_cnt == LAST_IDX)  state_d = ST_TAIL;
            end
            ST_TAIL:  if (cs_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sdo_en = 1'b0;
        sdo    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SHIFT: begin sdo_en = 1'b1; sdo = head_bit; end
            ST_TAIL:  sdo_en = 1'b1;
            default:  ;
        endcase
    end

    // R1
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_en);

    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && $past(sdo_en) && !$past(sclk_fall)) |-> $stable(sdo));

    // R4
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> (sdo == 1'b0 && bit_cnt == '0));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));
endmodule

// File: tb/adc_result_shifter_tb.sv
module adc_result_shifter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic [13:0] res = '0;
    logic [1:0]  st = '0;
    logic sdo, sdo_en;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adc_result_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .conv_result(res), .conv_status(st), .sdo(sdo), .sdo_en(sdo_en));

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic string req_of(input int i);
        if (i < 8) return "R4";
        if (i < 22) return "R5";
        return "R6";
    endfunction

    // Send nbits clocks; expected frame built from the requirements.
    task automatic run_frame(input logic [13:0] r, input logic [1:0] s,
                             input int nbits, input int extra,
                             input bit poke_inputs);
        logic [23:0] fr;
        fr = {8'h00, r, s};
        res = r; st = s;
        cs_n = 1'b0;
        settle();
        if (poke_inputs) begin res = ~r; st = ~s; end  // R2
        check("R4_en", sdo_en, 1'b1);
        for (int i = 0; i < nbits; i++) begin
            check(poke_inputs ? "R2" : req_of(i), sdo, fr[23-i]);
            sclk = 1'b1; settle();
            check("R3", sdo, fr[23-i]);
            sclk = 1'b0; settle();
        end
        for (int k = 0; k < extra; k++) begin
            check("R7", sdo, 1'b0);
            check("R7_en", sdo_en, 1'b1);
            sclk = 1'b1; settle();
            sclk = 1'b0; settle();
        end
        if (extra > 0) check("R7", sdo, 1'b0);
        cs_n = 1'b1;
        settle();
        check(nbits < 24 ? "R8" : "R1", sdo_en, 1'b0);
        check("R1", sdo, 1'b0);
    endtask

    task automatic t_reset();
        check("R1_rst", sdo_en, 1'b0);
        check("R1_rst", sdo, 1'b0);
        sclk = 1'b1; settle(); sclk = 1'b0; settle();
        check("R1_idle_clk", sdo_en, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        run_frame(14'h2A5C, 2'b10, 24, 0, 0);
        run_frame(14'h3FFF, 2'b11, 24, 0, 0);
        run_frame(14'h0001, 2'b01, 24, 3, 0);   // R7 tail
        run_frame(14'h1234, 2'b10, 24, 0, 1);   // R2 capture
        run_frame(14'h3C3C, 2'b01, 13, 0, 0);   // R8 abort
        run_frame(14'h0F0F, 2'b10, 24, 0, 0);   // R8 restart at bit 0
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule